// File: doc/BRIEF.md
# Static Clock Stop/Start Controller

This block derives the clocks of a static processor system from a free-running oscillator reference. The block runs on that reference. It drives level outputs for a processor clock, a peripheral clock, a square-wave clock and an oscillator tap enable. Downstream gating cells turn these levels into real clocks.

The processor halts its own clocks by driving its three status lines through a two-step pattern. It can ask for either of two halt depths. In the shallow depth only the derived clocks freeze and the oscillator tap keeps running. In the deep depth the oscillator tap is also withheld. An active-high start line resumes the clocks. An interrupt request line is a typical choice for this input.

After a deep halt, the outputs stay quiet while the oscillator settles. The oscillator must be flagged stable, and then a fixed number of reference cycles must pass. After that, every output restarts together from the first phase of its frame.

A fast/slow input selects the processor clock rate. In slow mode the processor and peripheral clocks advance one phase every `SLOW_DIV` reference cycles. In fast mode they advance every cycle.

Top module: `stclk_ctrl`

## Requirements
- R1: A halt is armed only when the status lines (bit 2 is the top line) read 3'b111 on one cycle and 3'b011 on the next cycle. No other sequence of status values changes `mode`.
- R2: While `start` is high, no halt is armed or taken, and `mode` stays 0. This holds even when `start` is already high as reset is released.
- R3: `mode` reports 0 for run, 1 for clock-only halt, 2 for oscillator halt and 3 for settling. A synchronous reset gives run mode with every divider at phase 0: `cpu_clk`, `pclk` and `clk50` are high and `osc_en` is high in the first cycle after reset.
- R4: In fast mode the outputs follow a six-cycle frame that starts at phase 0.
  - `cpu_clk` is high in phases 0 and 3, which is the reference divided by 3 at one-third duty.
  - `pclk` is high in phases 0 to 2, which is `cpu_clk` divided by 2.
  - `clk50` is high in phases 0 to 2 of its own reference-rate counter, which is the reference divided by 6 at half duty.
- R5: With `fast` low, the phase counter for `cpu_clk` and `pclk` advances once every `SLOW_DIV` cycles. `clk50` keeps its reference/6 rate.
- R6: An armed halt takes effect only at the end of phase 5, after which `cpu_clk` is low. A complete `cpu_clk` high pulse is never cut short. The halt depth is taken from `halt_osc` at that moment. While halted, `cpu_clk`, `pclk` and `clk50` are low.
- R7: In mode 1, `osc_en` stays high. A high `start` returns the block to mode 0 on the next edge, with all outputs at phase 0.
- R8: In mode 2, `osc_en` is low, and a high `start` moves the block to mode 3.
  - Mode 3 is left only after `osc_stable` has been high for `SETTLE_CYCLES` consecutive cycles. A low `osc_stable` restarts the count.
  - The block then enters mode 0 at phase 0, with `osc_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator reference clock |
| rst | input | 1 | Synchronous active-high reset |
| status | input | 3 | Processor status lines, bit 2 is the top line |
| start | input | 1 | Active-high resume request |
| fast | input | 1 | 1 selects fast rate, 0 selects slow rate |
| halt_osc | input | 1 | Halt depth: 1 also withholds the oscillator tap |
| osc_stable | input | 1 | Oscillator-stable flag |
| cpu_clk | output | 1 | Processor clock level |
| pclk | output | 1 | Peripheral clock level |
| clk50 | output | 1 | Half-duty reference/6 clock level |
| osc_en | output | 1 | Oscillator tap enable |
| mode | output | 2 | Current mode code |

## Verification
The embedded assertions check the following on every cycle:
- A high `start` keeps run mode.
- A halt is entered only when `cpu_clk` was low.
- Settling never ends while the oscillator is unstable.
- `pclk` rises only together with `cpu_clk`.
- A clock-only halt is left the edge after `start`.

Only the bench scenarios can show:
- the exact output waveforms in fast and slow mode;
- that invalid status sequences are ignored;
- the frame-aligned halt point after an armed pattern;
- the exact length of the settling count, including its restart when stability drops.

// File: rtl/stclk_pkg.sv
package stclk_pkg;
  typedef enum logic [1:0] {
    M_RUN      = 2'd0,
    M_STOP_CLK = 2'd1,
    M_STOP_OSC = 2'd2,
    M_SETTLE   = 2'd3
  } mode_e;
  localparam int unsigned FRAME_PHASES = 6;
endpackage

// File: rtl/stclk_stop_detect.sv
module stclk_stop_detect #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] status,
  input  logic          start,
  output logic          arm
);
  localparam logic [SW-1:0] ALL_HIGH  = '1;
  localparam logic [SW-1:0] HALT_CODE = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= status;
  end

  // R1: two-step pattern, R2: start overrides
  assign arm = (stat_q == ALL_HIGH) && (status == HALT_CODE) && !start;
endmodule

// File: rtl/stclk_divider.sv
module stclk_divider
  import stclk_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic fast,
  output logic cpu_clk,
  output logic pclk,
  output logic clk50,
  output logic frame_end
);
  localparam int unsigned SW   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int unsigned PW   = $clog2(FRAME_PHASES);
  localparam logic [PW-1:0] LAST = PW'(FRAME_PHASES - 1);
  localparam logic [PW-1:0] HALF = PW'(FRAME_PHASES / 2);

  logic [PW-1:0] ph_q, c50_q;
  logic [SW-1:0] scnt_q;
  logic          tick;

  generate
    if (SLOW_DIV > 1) begin : g_slow
      assign tick = fast || (scnt_q == SW'(SLOW_DIV - 1));
    end else begin : g_noslow
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      ph_q   <= '0;
      c50_q  <= '0;
      scnt_q <= '0;
    end else begin
      c50_q  <= (c50_q == LAST) ? '0 : c50_q + 1'b1;
      scnt_q <= (fast || tick) ? '0 : scnt_q + 1'b1;
      if (tick) ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign frame_end = run_en && tick && (ph_q == LAST);
  assign cpu_clk   = run_en && ((ph_q == '0) || (ph_q == HALF));
  assign pclk      = run_en && (ph_q < HALF);
  assign clk50     = run_en && (c50_q < HALF);

  // R4: peripheral clock edges line up with processor clock edges
  a_r4_pclk_with_cpu: assert property (@(posedge clk) disable iff (rst)
    $rose(pclk) |-> cpu_clk);
endmodule

// File: rtl/stclk_settle.sv
module stclk_settle #(
  parameter int unsigned COUNT = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic stable,
  output logic done
);
  localparam int unsigned CW = $clog2(COUNT + 1);

  logic [CW-1:0] cnt_q;

  assign done = active && stable && (cnt_q == CW'(COUNT - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || !stable || done) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + 1'b1;
  end

  // R8: counter never runs past its window
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(COUNT));
endmodule

// File: rtl/stclk_ctrl.sv
module stclk_ctrl
  import stclk_pkg::*;
#(
  parameter int unsigned SLOW_DIV      = 4,
  parameter int unsigned SETTLE_CYCLES = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] status,
  input  logic       start,
  input  logic       fast,
  input  logic       halt_osc,
  input  logic       osc_stable,
  output logic       cpu_clk,
  output logic       pclk,
  output logic       clk50,
  output logic       osc_en,
  output logic [1:0] mode
);
  mode_e mode_q, mode_d;
  logic  pend_q, pend_d;
  logic  arm, frame_end, settle_done, run_en;

  stclk_stop_detect #(.SW(3)) u_detect (
    .clk(clk), .rst(rst), .status(status), .start(start), .arm(arm)
  );

  assign run_en = (mode_q == M_RUN);

  stclk_divider #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst(rst), .run_en(run_en), .fast(fast),
    .cpu_clk(cpu_clk), .pclk(pclk), .clk50(clk50), .frame_end(frame_end)
  );

  stclk_settle #(.COUNT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .active(mode_q == M_SETTLE),
    .stable(osc_stable), .done(settle_done)
  );

  always_comb begin
    mode_d = mode_q;
    pend_d = run_en && !start && (pend_q || arm) && !frame_end;
    unique case (mode_q)
      M_RUN:      if ((pend_q || arm) && !start && frame_end)
                    mode_d = halt_osc ? M_STOP_OSC : M_STOP_CLK;
      M_STOP_CLK: if (start) mode_d = M_RUN;
      M_STOP_OSC: if (start) mode_d = M_SETTLE;
      M_SETTLE:   if (settle_done) mode_d = M_RUN;
      default:    mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_RUN;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mode   = mode_q;
  assign osc_en = (mode_q == M_RUN) || (mode_q == M_STOP_CLK);

  // R2: start held high keeps run mode
  a_r2_start_keeps_run: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 2'd0) |=> mode == 2'd0);
  // R6: a halt is entered only while the processor clock is low
  a_r6_halt_at_low: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'd0 && mode != 2'd0) |-> !$past(cpu_clk));
  // R7: clock-only halt leaves on the edge after start
  a_r7_fast_resume: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && start) |=> mode == 2'd0);
  // R8: settling never ends while the oscillator is unstable
  a_r8_wait_stable: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !osc_stable) |=> mode == 2'd3);
endmodule

// File: tb/stclk_ctrl_bench.sv
module stclk_ctrl_bench;
  localparam int unsigned SLOW_DIV = 4;
  localparam int unsigned SETTLE   = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] status = 3'b000;
  logic start = 1'b0, fast = 1'b1, halt_osc = 1'b0, osc_stable = 1'b0;
  logic cpu_clk, pclk, clk50, osc_en;
  logic [1:0] mode;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  stclk_ctrl #(.SLOW_DIV(SLOW_DIV), .SETTLE_CYCLES(SETTLE)) u_stclk_ctrl (
    .clk(clk), .rst(rst), .status(status), .start(start), .fast(fast),
    .halt_osc(halt_osc), .osc_stable(osc_stable), .cpu_clk(cpu_clk),
    .pclk(pclk), .clk50(clk50), .osc_en(osc_en), .mode(mode)
  );

  // fast-mode frame, {cpu_clk, pclk, clk50} per cycle after reset (R4)
  localparam logic [2:0] VEC [0:11] = '{
    3'b111, 3'b011, 3'b011, 3'b100, 3'b000, 3'b000,
    3'b111, 3'b011, 3'b011, 3'b100, 3'b000, 3'b000};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic put(input logic [2:0] v);
    status = v;
    cyc(1);
  endtask

  function automatic int outs();
    return {cpu_clk, pclk, clk50};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R3 reset state
    chk("R3 reset mode", mode, 0);
    chk("R3 reset osc_en", osc_en, 1);
    for (int i = 0; i < 12; i++) begin
      chk("R4 fast frame", outs(), VEC[i]);
      cyc(1);
    end

    // R5 slow rate
    fast = 1'b0;
    do_reset();
    for (int n = 0; n < 24; n++) begin
      chk("R5 slow cpu_clk", cpu_clk, ((n / SLOW_DIV) % 3) == 0);
      chk("R5 slow pclk", pclk, (n / SLOW_DIV) < 3);
      chk("R5 slow clk50", clk50, (n % 6) < 3);
      cyc(1);
    end
    fast = 1'b1;
    do_reset();

    // R1 invalid sequences are ignored
    put(3'b111); put(3'b001); put(3'b011);
    put(3'b110); put(3'b010);
    put(3'b111); put(3'b111); put(3'b101);
    put(3'b111); put(3'b000); put(3'b011);
    put(3'b000);
    cyc(14);
    chk("R1 ignored patterns", mode, 0);

    // R1/R6/R7 clock-only halt
    halt_osc = 1'b0;
    put(3'b111); put(3'b011); put(3'b000);
    cyc(12);
    chk("R1 halt taken", mode, 1);
    chk("R7 osc_en in clock halt", osc_en, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 quiet while halted", outs(), 0);
      cyc(1);
    end
    put(3'b111); put(3'b011); put(3'b000);
    cyc(4);
    chk("R6 halted stays halted", mode, 1);
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk("R7 resume mode", mode, 0);
    chk("R7 resume phase 0", outs(), 7);

    // R6 frame-aligned halt point, deep halt; now at phase 0
    halt_osc = 1'b1;
    put(3'b111);               // sample ph1 next
    put(3'b011);               // ph2 next
    status = 3'b000;
    cyc(1);                    // ph3
    chk("R6 full cpu pulse", cpu_clk, 1);
    cyc(2);                    // ph5
    chk("R6 waits frame end", mode, 0);
    cyc(1);
    chk("R6 halt after frame", mode, 2);
    chk("R8 osc_en off", osc_en, 0);
    chk("R6 outputs low", outs(), 0);
    halt_osc = 1'b0;

    // R8 settle
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk("R8 settle entered", mode, 3);
    cyc(50);
    chk("R8 waits stable flag", mode, 3);
    osc_stable = 1'b1;
    cyc(100);
    osc_stable = 1'b0;
    cyc(1);
    osc_stable = 1'b1;
    cyc(SETTLE - 1);
    chk("R8 count not done", mode, 3);
    chk("R8 outputs quiet", outs(), 0);
    cyc(1);
    chk("R8 run after count", mode, 0);
    chk("R8 phase 0 restart", outs(), 7);
    chk("R8 osc_en back", osc_en, 1);

    // R2 start high through reset
    start = 1'b1;
    do_reset();
    put(3'b111); put(3'b011); put(3'b000);
    cyc(20);
    chk("R2 start holds run", mode, 0);
    start = 1'b0;
    cyc(10);
    chk("R2 no late halt", mode, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule